// File: doc/BRIEF.md
# Shift-Add Multiplier Sequencer

This block is the control unit for a multi-cycle shift-and-add multiplier. The multiplier shares one system data bus with other units. On a start request the sequencer takes the multiplicand and then the multiplier from the bus into their registers and clears the partial product. It then steps the datapath once per operand bit. In each step the multiplicand shifts left, the multiplier shifts right, and the partial product takes the adder output only when the multiplier's low bit is set. At the end it lets the product register drive the bus for a single cycle.

The same controller handles unsigned and two's-complement operands. For signed operands the step that consumes the multiplier's sign bit turns the adder into a subtractor. The operand width is chosen per operation: 8, 16 or 32 bits use a fixed step count taken from an internal loadable down counter. A fourth, open-width mode runs until the datapath's all-zero or all-one flags for the multiplier register show that no useful step is left. A parameter mask selects which of the four modes the build offers. A request for an absent mode is refused with a flag and produces no datapath activity.

Top module: `mul_seq`

## Requirements
- R1: While idle, a start sampled high at a rising clock edge makes the next cycle a multiplicand load cycle: `ld_a` high with `shift` low.
- R2: A start that is high while an operation is in progress is ignored. Exactly one load sequence and one product output occur per accepted start.
- R3: With start held high, operations run back to back. In the 8-bit mode consecutive multiplicand loads are 12 cycles apart: load A, load B, 8 steps, output, idle.
- R4: The cycle after the multiplicand load asserts `ld_b`, `ld_p` and `clr_p` together with `shift` low. This loads B and zeroes P.
- R5: Each step cycle asserts `ld_a`, `ld_b` and `shift`, and asserts `ld_p` exactly when `b_lsb` is 1. Mode encoding on `mode`: 00 gives 8 steps, 01 gives 16 steps, 10 gives 32 steps, and 11 selects open width.
- R6: `sub` is high only on a step of a signed operation, and in the fixed modes only on the final step. An unsigned operation never asserts it.
- R7: In open-width mode, a step cycle in which `b_zero` is high issues no strobes, and the output cycle follows. An unsigned operation ignores `b_ones`.
- R8: In open-width signed mode, a step cycle with `b_ones` high performs one subtract step (`ld_p`, `sub`, `shift`), and the output cycle follows.
- R9: `drive_p` is high for exactly one cycle, in the cycle after the last step.
- R10: A start for a mode whose bit in `MODE_EN` is 0 raises `bad_mode` for one cycle with no strobe or `drive_p`, and the block then returns to idle. A build that supports the mode never raises `bad_mode`.
- R11: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request |
| is_signed | input | 1 | Operands are two's complement |
| mode | input | 2 | Width mode (00=8, 01=16, 10=32, 11=open) |
| b_lsb | input | 1 | Low bit of multiplier register |
| b_zero | input | 1 | Multiplier register is all zeros |
| b_ones | input | 1 | Multiplier register is all ones |
| ld_a | output | 1 | Update multiplicand register |
| ld_b | output | 1 | Update multiplier register |
| ld_p | output | 1 | Update partial product register |
| shift | output | 1 | Select shift path for A and B (low selects bus) |
| clr_p | output | 1 | Select zero as the value loaded into P |
| sub | output | 1 | Adder subtracts instead of adds |
| drive_p | output | 1 | Product register drives the bus |
| bad_mode | output | 1 | Requested mode is not offered |

## Verification
The hardest cases to reach are the open-width exits. These depend on the bit pattern that remains in the multiplier register as it shifts, so they come only from a working datapath. The bench therefore wraps the sequencer in a behavioural datapath whose flags come from a shifting B register. It picks multipliers of zero, minus one, small negatives, the most negative value and all-ones unsigned, so that each exit path fires at a known step. A second instance built without open-width support receives the same requests, which exercises the refusal path.

// File: rtl/mul_seq.sv
module mul_seq #(
  parameter int STEPS0 = 8,
  parameter int STEPS1 = 16,
  parameter int STEPS2 = 32,
  parameter logic [3:0] MODE_EN = 4'b1111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_signed,
  input  logic [1:0] mode,
  input  logic       b_lsb,
  input  logic       b_zero,
  input  logic       b_ones,
  output logic       ld_a,
  output logic       ld_b,
  output logic       ld_p,
  output logic       shift,
  output logic       clr_p,
  output logic       sub,
  output logic       drive_p,
  output logic       bad_mode
);

  localparam int MAXS = (STEPS0 > STEPS1) ? ((STEPS0 > STEPS2) ? STEPS0 : STEPS2)
                                          : ((STEPS1 > STEPS2) ? STEPS1 : STEPS2);
  localparam int CW = (MAXS > 2) ? $clog2(MAXS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LDA, S_LDB, S_STEP, S_OUT, S_REJ} st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_init;
  logic cnt_load, cnt_zero;

  wire open_w   = (mode == 2'b11);
  wire in_step  = (st == S_STEP);
  wire stop_now = open_w && b_zero;
  wire sgn_end  = open_w && is_signed && b_ones && !b_zero;
  wire last     = open_w ? sgn_end : cnt_zero;
  wire active   = in_step && !stop_now;

  always_comb begin
    case (mode)
      2'b00:   cnt_init = CW'(STEPS0 - 1);
      2'b01:   cnt_init = CW'(STEPS1 - 1);
      default: cnt_init = CW'(STEPS2 - 1);
    endcase
  end

  assign cnt_load = (st == S_LDB);
  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt_load)      cnt <= cnt_init;
    else if (in_step && !cnt_zero) cnt <= cnt - 1'b1;
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (start) st_n = MODE_EN[mode] ? S_LDA : S_REJ;
      S_LDA:  st_n = S_LDB;
      S_LDB:  st_n = S_STEP;
      S_STEP: if (stop_now || last) st_n = S_OUT;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_n;
  end

  assign ld_a     = (st == S_LDA) || active;
  assign ld_b     = (st == S_LDB) || active;
  assign ld_p     = (st == S_LDB) || (active && b_lsb);
  assign shift    = active;
  assign clr_p    = (st == S_LDB);
  assign sub      = active && is_signed && last;
  assign drive_p  = (st == S_OUT);
  assign bad_mode = (st == S_REJ);

  // R5: a shift always moves both operand registers
  a_r5_shift_pair: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (ld_a && ld_b));

  // R6: subtract only within a signed step
  a_r6_sub_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sub |-> (shift && is_signed));

  // R9: product output lasts one cycle
  a_r9_drive_once: assert property (@(posedge clk) disable iff (!rst_n)
    drive_p |=> !drive_p);

  // R10: a refused request stays off the datapath and returns to idle
  a_r10_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> !(ld_a || ld_b || ld_p || drive_p));
  a_r10_reject_short: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> !bad_mode);

  // R4: P is cleared while B loads from the bus
  a_r4_clear_with_b: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |-> (ld_p && ld_b && !shift && !ld_a));

  // R2: no fresh load while busy
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> !(ld_a && !shift));

  // R7: an all-zero multiplier in open width ends the run
  a_r7_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_step && open_w && b_zero) |=> drive_p);

  // R8: an all-one signed multiplier gets a final subtract then output
  a_r8_ones_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_step && open_w && is_signed && b_ones && !b_zero) |-> (sub && ld_p) ##1 drive_p);

endmodule

// File: tb/mul_seq_tb.sv
module mul_seq_tb;
  localparam int TCK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic start = 1'b0, is_signed = 1'b0;
  logic [1:0] mode = 2'b00;
  logic b_lsb, b_zero, b_ones;
  logic ld_a, ld_b, ld_p, shift, clr_p, sub, drive_p, bad_mode;
  logic n_ld_a, n_ld_b, n_ld_p, n_shift, n_clr_p, n_sub, n_drive_p, n_bad_mode;

  always #(TCK/2) clk = ~clk;

  mul_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed), .mode(mode),
    .b_lsb(b_lsb), .b_zero(b_zero), .b_ones(b_ones),
    .ld_a(ld_a), .ld_b(ld_b), .ld_p(ld_p), .shift(shift), .clr_p(clr_p),
    .sub(sub), .drive_p(drive_p), .bad_mode(bad_mode));

  mul_seq #(.MODE_EN(4'b0111)) u_nomode3 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed), .mode(mode),
    .b_lsb(b_lsb), .b_zero(b_zero), .b_ones(b_ones),
    .ld_a(n_ld_a), .ld_b(n_ld_b), .ld_p(n_ld_p), .shift(n_shift), .clr_p(n_clr_p),
    .sub(n_sub), .drive_p(n_drive_p), .bad_mode(n_bad_mode));

  // behavioural datapath stand-in
  logic [63:0] reg_a, reg_p, bus_a;
  logic [31:0] reg_b, bus_b;
  always @(posedge clk) begin
    if (ld_a) reg_a <= shift ? (reg_a << 1) : bus_a;
    if (ld_b) reg_b <= shift ? ((is_signed && mode == 2'b11) ? {reg_b[31], reg_b[31:1]} : (reg_b >> 1)) : bus_b;
    if (ld_p) reg_p <= clr_p ? 64'd0 : (sub ? reg_p - reg_a : reg_p + reg_a);
  end
  assign b_lsb  = reg_b[0];
  assign b_zero = (reg_b == 32'd0);
  assign b_ones = &reg_b;

  typedef struct { logic [63:0] prod; logic [63:0] mask; int steps; int subs; } exp_t;
  exp_t q[$];

  int nvec = 0, nbad = 0, cyc = 0;
  int steps_cur = 0, subs_cur = 0, loads = 0, accepted = 0, dut_bad = 0;
  int nm_bad = 0, nm_strobes = 0, last_load = 0, prev_load = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) if (rst_n) begin
    if (shift) steps_cur++;
    if (sub) subs_cur++;
    if (bad_mode) dut_bad++;
    if (n_bad_mode) nm_bad++;
    if (n_ld_a || n_ld_b || n_ld_p || n_drive_p) nm_strobes++;
    if (ld_a && !shift) begin
      loads++; prev_load = last_load; last_load = cyc; steps_cur = 0; subs_cur = 0;
    end
    if (drive_p) begin
      if (q.size() == 0) chk(1'b0, "R2 unexpected product", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk((reg_p & e.mask) == e.prod, "R5 product", reg_p & e.mask, e.prod);
        chk(steps_cur == e.steps, "R5/R7/R8 step count", 64'(steps_cur), 64'(e.steps));
        chk(subs_cur == e.subs, "R6/R8 subtract count", 64'(subs_cur), 64'(e.subs));
      end
    end
  end

  function automatic logic [63:0] ext(input logic [63:0] v, input int n, input bit sg);
    logic [63:0] m;
    m = (n >= 64) ? '1 : ((64'd1 << n) - 1);
    ext = v & m;
    if (sg && v[n-1]) ext = ext | ~m;
  endfunction

  function automatic exp_t model(input logic [1:0] md, input bit sg, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    int n;
    logic [31:0] bb;
    n = (md == 2'b11) ? 32 : (8 << md);
    e.prod = ext(64'(a), n, sg) * ext(64'(b), n, sg);
    e.mask = (2*n >= 64) ? '1 : ((64'd1 << (2*n)) - 1);
    e.prod = e.prod & e.mask;
    if (md != 2'b11) begin
      e.steps = n; e.subs = sg ? 1 : 0;
    end else begin
      e.steps = 0; e.subs = 0; bb = b;
      for (int i = 0; i < 40; i++) begin
        if (bb == 32'd0) break;
        if (sg && bb == '1) begin e.steps++; e.subs = 1; break; end
        e.steps++;
        bb = sg ? {bb[31], bb[31:1]} : (bb >> 1);
      end
    end
    return e;
  endfunction

  task automatic setup(input logic [1:0] md, input bit sg, input logic [31:0] a, input logic [31:0] b);
    int n;
    n = (md == 2'b11) ? 32 : (8 << md);
    @(negedge clk);
    mode = md; is_signed = sg;
    bus_a = ext(64'(a), n, sg);
    bus_b = 32'(ext(64'(b), n, 1'b0));
    q.push_back(model(md, sg, a, b));
  endtask

  task automatic run_op(input logic [1:0] md, input bit sg, input logic [31:0] a, input logic [31:0] b, input bit extra);
    int ld_before;
    setup(md, sg, a, b);
    ld_before = cyc;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ld_a && !shift, "R1 load A follows start", 64'(ld_a), 64'd1);
    @(negedge clk);
    chk(ld_b && ld_p && clr_p && !shift, "R4 load B and clear P", {ld_b, ld_p, clr_p, shift}, 4'b1110);
    accepted++;
    if (extra) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!drive_p) @(negedge clk);
    @(negedge clk);
    chk(!drive_p, "R9 single output cycle", 64'(drive_p), 64'd0);
  endtask

  initial begin : wdog
    wait (cyc > 150000);
    nvec++; nbad++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    bus_a = '0; bus_b = '0;
    #2 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({ld_a, ld_b, ld_p, shift, clr_p, sub, drive_p, bad_mode} == 8'd0, "R11 outputs low in reset",
        {ld_a, ld_b, ld_p, shift, clr_p, sub, drive_p, bad_mode}, 8'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(2'b00, 1'b0, 32'd200, 32'd150, 1'b0);
    run_op(2'b00, 1'b1, 32'hC3, 32'hA9, 1'b0);
    run_op(2'b00, 1'b1, 32'h35, 32'h7E, 1'b1);      // R2: stray start mid-run
    repeat (15) @(negedge clk);
    chk(loads == accepted, "R2 stray start ignored", 64'(loads), 64'(accepted));
    run_op(2'b01, 1'b1, 32'h8001, 32'hFFFD, 1'b0);
    run_op(2'b01, 1'b0, 32'hBEEF, 32'h1234, 1'b0);
    run_op(2'b10, 1'b0, 32'hDEADBEEF, 32'hFFFFFFFF, 1'b0);
    run_op(2'b10, 1'b1, 32'h80000000, 32'h80000000, 1'b0);

    nm_bad = 0; nm_strobes = 0;
    run_op(2'b11, 1'b0, 32'h1234, 32'd0, 1'b0);     // R7 zero at once
    chk(nm_bad == 1, "R10 refused mode flagged once", 64'(nm_bad), 64'd1);
    chk(nm_strobes == 0, "R10 refused mode no strobes", 64'(nm_strobes), 64'd0);
    run_op(2'b11, 1'b0, 32'h777, 32'h35, 1'b0);     // R7
    run_op(2'b11, 1'b0, 32'h5, 32'hFFFFFFFF, 1'b0); // R7 b_ones ignored unsigned
    run_op(2'b11, 1'b1, 32'hFFFFFF9C, 32'hFFFFFFFF, 1'b0); // R8 minus one
    run_op(2'b11, 1'b1, 32'd1000, 32'hFFFFFFFA, 1'b0);     // R8 minus six
    run_op(2'b11, 1'b1, 32'hFFFFFFF1, 32'd100, 1'b0);      // R7 signed positive
    run_op(2'b11, 1'b1, 32'd3, 32'h80000000, 1'b0);        // R8 most negative

    // R3: start held high
    nm_bad = 0;
    for (int k = 0; k < 3; k++) q.push_back(model(2'b00, 1'b0, 32'd13, 32'd11));
    @(negedge clk);
    mode = 2'b00; is_signed = 1'b0; bus_a = 64'd13; bus_b = 32'd11;
    start = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      while (!drive_p) @(negedge clk);
      if (k == 1) chk(last_load - prev_load == 12, "R3 back-to-back spacing", 64'(last_load - prev_load), 64'd12);
    end
    start = 1'b0;
    accepted += 3;
    repeat (15) @(negedge clk);
    chk(loads == accepted, "R3 run count", 64'(loads), 64'(accepted));
    chk(q.size() == 0, "R3 all products seen", 64'(q.size()), 64'd0);
    chk(nm_bad == 0, "R10 supported mode not flagged", 64'(nm_bad), 64'd0);
    chk(dut_bad == 0, "R10 full build never refuses", 64'(dut_bad), 64'd0);

    // R11: asynchronous reset mid-run
    @(negedge clk);
    mode = 2'b10; start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk({ld_a, ld_b, ld_p, shift, clr_p, sub, drive_p, bad_mode} == 8'd0, "R11 async reset clears outputs",
           {ld_a, ld_b, ld_p, shift, clr_p, sub, drive_p, bad_mode}, 8'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(drive_p == 1'b0 && ld_a == 1'b0, "R11 idle after reset", {drive_p, ld_a}, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule